// File: doc/BRIEF.md
# Digital Rate-Trim Seconds Divider

This block turns a stream of oscillator ticks into a one-second timebase. A 32,768 Hz crystal yields 32,768 ticks per second. The rate is trimmed digitally, with no analog adjustment. Inside a repeating cycle of 64 minutes, the block picks out some seconds and makes each one shorter or longer by a fixed number of ticks. A 6-bit calibration word sets the trim. The top bit gives the direction and the low five bits give a magnitude N. The first 2N minutes of each cycle are trimmed, and only the opening second of each of those minutes changes.

The divider chain has two parts. A free-running front counter of 128 ticks produces half-period events. A pairing stage turns those events into one carry every 256 ticks, and a seconds stage counts 128 of those carries. Trim is applied in the pairing stage:
- To speed the clock up, one carry is counted twice.
- To slow it down, one half event is dropped.

The 512 Hz tap comes from the front counter, so the calibration word cannot change it. The block also keeps its own second-in-minute counter and minute-in-cycle counter and uses them to decide which seconds to trim.

Top module: `clkcal_top`

## Requirements
- R1: While reset is held, `sec_pulse`, `min_strobe`, `tap_512` and `carry_256` are all 0. Reset clears the front counter, the pairing stage, the second counter and the minute counter.
- R2: With magnitude 0, every second lasts 2·2^HALF_W·SEC_CARRIES ticks (32,768 by default), whatever the direction bit.
- R3: With the direction bit (bit MAG_W of `cal_word`) set to 1 and a nonzero magnitude, each trimmed second is shorter by 2^(HALF_W+1) ticks (256 by default).
- R4: With the direction bit at 0 and a nonzero magnitude, each trimmed second is longer by 2^HALF_W ticks (128 by default).
- R5: Only the first second of a minute (second index 0) is ever trimmed. All other seconds keep the nominal length.
- R6: With magnitude N, the first second of minutes 0 to 2N−1 of the cycle is trimmed. If 2N is at least MINS_PER_CYCLE, every minute is trimmed.
- R7: `cal_word` is captured on the first tick after reset and on the tick that ends the last minute of a cycle. A change made during a cycle has no effect until the next cycle begins.
- R8: `tap_512` toggles every 2^(HALF_W−2) ticks (512 Hz by default) and changes only after a tick. The calibration word never changes its timing.
- R9: In an untrimmed second, `carry_256` pulses once every 2^(HALF_W+1) ticks (256 by default).
- R10: `min_strobe` pulses together with every SECS_PER_MIN-th `sec_pulse`, and only then.
- R11: Nothing advances when `tick_en` is low. With ticks arriving every other clock, a second lasts twice as many clocks as it has ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One oscillator tick when high at a clock edge |
| cal_word | input | MAG_W+1 | Bit MAG_W is the direction (1 = faster). Bits MAG_W-1:0 are the magnitude |
| sec_pulse | output | 1 | One-clock pulse at the end of each second |
| min_strobe | output | 1 | One-clock pulse at the end of each minute |
| tap_512 | output | 1 | Square wave at the 512 Hz reference rate |
| carry_256 | output | 1 | Corrected output of the divide-by-256 stage |

## Verification
The hardest case to reach from the ports is a calibration change made in the middle of a cycle. To see that it is held off, the bench must run through the rest of the cycle and show that every remaining second stays nominal. It must then cross into the next cycle and show that the new trim appears at once. The bench uses a small configuration (8-tick halves, 4 carries per second, 4 seconds per minute, 8 minutes per cycle), so a whole cycle takes about 2,000 clocks. It then checks the length of every second against a model computed from second index, minute and magnitude. It also exercises the cases where some minutes are trimmed and some are not, and the case where the window covers the whole cycle.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;
   typedef enum logic {
      TRIM_SLOW = 1'b0,
      TRIM_FAST = 1'b1
   } trim_dir_t;
endpackage

// File: rtl/clkcal_prescale.sv
module clkcal_prescale #(
   parameter int HALF_W = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic half_ev,
   output logic tap
);
   localparam int TAP_BIT = HALF_W - 2;

   logic [HALF_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lo_q <= '0;
      else if (tick) lo_q <= lo_q + 1'b1;
   end

   assign half_ev = tick && (&lo_q);
   assign tap     = lo_q[TAP_BIT];

   // R8: the reference tap moves only after an oscillator tick
   a_r8_tap_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tap) |-> $past(tick));
endmodule

// File: rtl/clkcal_stage256.sv
module clkcal_stage256 (
   input  logic clk,
   input  logic rst_n,
   input  logic half_ev,
   input  logic req_slow,
   input  logic req_fast,
   output logic carry,
   output logic carry_dbl,
   output logic applied
);
   logic ph_q;
   logic blank;
   logic eff;

   assign blank     = half_ev && req_slow;
   assign eff       = half_ev && !req_slow;
   assign carry     = eff && ph_q;
   assign carry_dbl = carry && req_fast;
   assign applied   = blank || carry_dbl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ph_q <= 1'b0;
      else if (eff) ph_q <= ~ph_q;
   end

   // R4: a blanked half event leaves the pairing phase untouched
   a_r4_blank_holds_phase: assert property (@(posedge clk) disable iff (!rst_n)
      blank |=> ph_q == $past(ph_q));
endmodule

// File: rtl/clkcal_timebase.sv
module clkcal_timebase #(
   parameter int SEC_CARRIES    = 128,
   parameter int SECS_PER_MIN   = 60,
   parameter int MINS_PER_CYCLE = 64,
   parameter int MAG_W          = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             carry,
   input  logic             carry_dbl,
   input  logic             applied,
   input  logic [MAG_W:0]   cal_word,
   output logic             req_slow,
   output logic             req_fast,
   output logic             sec_end,
   output logic             min_end
);
   import clkcal_pkg::*;

   localparam int SC_W  = $clog2(SEC_CARRIES + 2);
   localparam int SI_W  = $clog2(SECS_PER_MIN);
   localparam int MI_W  = $clog2(MINS_PER_CYCLE);
   localparam int CMP_W = ((MI_W > MAG_W + 1) ? MI_W : MAG_W + 1) + 1;

   logic [SC_W-1:0]  sc_q, sc_sum;
   logic [SI_W-1:0]  sidx_q;
   logic [MI_W-1:0]  minute_q;
   logic [MAG_W-1:0] lock_mag_q;
   trim_dir_t        lock_dir_q;
   logic             first_q, done_q;
   logic             last_sec, last_min, cyc_end, elig;
   logic [CMP_W-1:0] min_x, window;

   assign sc_sum   = sc_q + (carry_dbl ? SC_W'(2) : SC_W'(1));
   assign sec_end  = carry && (sc_sum >= SC_W'(SEC_CARRIES));
   assign last_sec = (sidx_q == SI_W'(SECS_PER_MIN - 1));
   assign last_min = (minute_q == MI_W'(MINS_PER_CYCLE - 1));
   assign min_end  = sec_end && last_sec;
   assign cyc_end  = min_end && last_min;

   assign min_x  = CMP_W'(minute_q);
   assign window = CMP_W'({lock_mag_q, 1'b0});
   assign elig   = (sidx_q == '0) && (min_x < window) && !done_q;

   assign req_slow = elig && (lock_dir_q == TRIM_SLOW);
   assign req_fast = elig && (lock_dir_q == TRIM_FAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_q     <= '0;
         sidx_q   <= '0;
         minute_q <= '0;
         done_q   <= 1'b0;
      end else if (carry) begin
         sc_q <= sec_end ? '0 : sc_sum;
         if (sec_end) begin
            done_q <= 1'b0;
            sidx_q <= last_sec ? '0 : sidx_q + 1'b1;
            if (last_sec) minute_q <= last_min ? '0 : minute_q + 1'b1;
         end else if (applied) begin
            done_q <= 1'b1;
         end
      end else if (applied) begin
         done_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q    <= 1'b1;
         lock_mag_q <= '0;
         lock_dir_q <= TRIM_SLOW;
      end else if (tick && (first_q || cyc_end)) begin
         first_q    <= 1'b0;
         lock_mag_q <= cal_word[MAG_W-1:0];
         lock_dir_q <= trim_dir_t'(cal_word[MAG_W]);
      end
   end

   // R5: a trim only ever lands in the opening second of a minute
   a_r5_trim_first_second: assert property (@(posedge clk) disable iff (!rst_n)
      applied |-> sidx_q == '0);
   // R6: a trim only lands inside the 2N-minute window
   a_r6_trim_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      applied |-> min_x < window);
   // R7: the captured calibration changes only at a cycle boundary
   a_r7_lock_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lock_mag_q) |-> (minute_q == '0 && sidx_q == '0 && sc_q == '0));
   // R11: without a tick the second index holds
   a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(sidx_q));
endmodule

// File: rtl/clkcal_top.sv
module clkcal_top #(
   parameter int HALF_W         = 7,
   parameter int SEC_CARRIES    = 128,
   parameter int SECS_PER_MIN   = 60,
   parameter int MINS_PER_CYCLE = 64,
   parameter int MAG_W          = 5,
   parameter bit OUT_REG        = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick_en,
   input  logic [MAG_W:0] cal_word,
   output logic           sec_pulse,
   output logic           min_strobe,
   output logic           tap_512,
   output logic           carry_256
);
   if (HALF_W < 3)         begin : g_bad_half $error("HALF_W must be at least 3"); end
   if (SEC_CARRIES < 4)    begin : g_bad_sc   $error("SEC_CARRIES must be at least 4"); end
   if (SECS_PER_MIN < 2)   begin : g_bad_spm  $error("SECS_PER_MIN must be at least 2"); end
   if (MINS_PER_CYCLE < 2) begin : g_bad_mpc  $error("MINS_PER_CYCLE must be at least 2"); end
   if (MAG_W < 1)          begin : g_bad_mag  $error("MAG_W must be at least 1"); end

   logic half_ev, req_slow, req_fast;
   logic carry, carry_dbl, applied;
   logic sec_end, min_end;

   clkcal_prescale #(.HALF_W(HALF_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick_en),
      .half_ev(half_ev), .tap(tap_512));

   clkcal_stage256 u_stage (
      .clk(clk), .rst_n(rst_n), .half_ev(half_ev),
      .req_slow(req_slow), .req_fast(req_fast),
      .carry(carry), .carry_dbl(carry_dbl), .applied(applied));

   clkcal_timebase #(
      .SEC_CARRIES(SEC_CARRIES), .SECS_PER_MIN(SECS_PER_MIN),
      .MINS_PER_CYCLE(MINS_PER_CYCLE), .MAG_W(MAG_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .tick(tick_en),
      .carry(carry), .carry_dbl(carry_dbl), .applied(applied),
      .cal_word(cal_word), .req_slow(req_slow), .req_fast(req_fast),
      .sec_end(sec_end), .min_end(min_end));

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sec_pulse  <= 1'b0;
            min_strobe <= 1'b0;
            carry_256  <= 1'b0;
         end else begin
            sec_pulse  <= sec_end;
            min_strobe <= min_end;
            carry_256  <= carry;
         end
      end
   end else begin : g_out_comb
      assign sec_pulse  = sec_end;
      assign min_strobe = min_end;
      assign carry_256  = carry;
   end

   // R10: every minute strobe coincides with a seconds pulse
   a_r10_min_with_sec: assert property (@(posedge clk) disable iff (!rst_n)
      min_strobe |-> sec_pulse);
endmodule

// File: tb/sim_clkcal_top.sv
module sim_clkcal_top;
   localparam int HW = 3, SC = 4, SPM = 4, MPC = 8, MW = 5;
   localparam int NOM  = 2 * (1 << HW) * SC;   // 64 ticks
   localparam int FAST = NOM - (1 << (HW + 1)); // 48
   localparam int SLOW = NOM + (1 << HW);       // 72

   logic clk = 0, rst_n = 0, tick_en = 0;
   logic [MW:0] cal_word = '0;
   logic sec_pulse, min_strobe, tap_512, carry_256;

   clkcal_top #(.HALF_W(HW), .SEC_CARRIES(SC), .SECS_PER_MIN(SPM),
                .MINS_PER_CYCLE(MPC), .MAG_W(MW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cal_word(cal_word),
      .sec_pulse(sec_pulse), .min_strobe(min_strobe),
      .tap_512(tap_512), .carry_256(carry_256));

   always #2 clk = ~clk;

   int n_run = 0, n_fail = 0;
   int cyc = 0, n_sec = 0;
   int sec_t[0:127];
   bit sec_m[0:127];
   int tick_mode = 0;
   bit alt = 0;
   logic last_tap = 0;
   int tap_last_t = 0, tap_n = 0, tap_bad = 0, tap_bad_v = 0;
   int car_last_t = 0, car_n = 0, car_bad = 0, car_bad_v = 0;

   initial forever begin
      @(negedge clk);
      alt = ~alt;
      tick_en = (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? alt : 1'b0;
   end

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (sec_pulse) begin
            if (n_sec < 128) begin sec_t[n_sec] = cyc; sec_m[n_sec] = min_strobe; end
            n_sec++;
         end
         if (tap_512 !== last_tap) begin
            if (tap_n > 0 && (cyc - tap_last_t) != 2) begin tap_bad++; tap_bad_v = cyc - tap_last_t; end
            tap_n++; tap_last_t = cyc; last_tap = tap_512;
         end
         if (carry_256) begin
            if (car_n > 0 && (cyc - car_last_t) != 16) begin car_bad++; car_bad_v = cyc - car_last_t; end
            car_n++; car_last_t = cyc;
         end
      end
   end

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(logic [MW:0] cw, int mode);
      rst_n = 0; tick_mode = mode; cal_word = cw;
      repeat (4) @(negedge clk);
      n_sec = 0; tap_n = 0; tap_bad = 0; car_n = 0; car_bad = 0; last_tap = 0;
      rst_n = 1;
   endtask

   task automatic wait_secs(int n);
      while (n_sec < n) @(negedge clk);
   endtask

   function automatic int exp_len(int k, int mag, bit fast);
      bit mod = (mag != 0) && (k % SPM == 0) && (((k / SPM) % MPC) < 2 * mag);
      return mod ? (fast ? FAST : SLOW) : NOM;
   endfunction

   task automatic t_reset;
      rst_n = 0; tick_mode = 0;
      repeat (3) @(negedge clk);
      check("R1 sec_pulse in reset", sec_pulse, 0);
      check("R1 min_strobe in reset", min_strobe, 0);
      check("R1 tap in reset", tap_512, 0);
      check("R1 carry in reset", carry_256, 0);
   endtask

   task automatic t_lengths(string req, int mag, bit fast, int nsec);
      int bad = 0, badk = 0, bada = 0, bade = 0;
      do_reset({fast, 5'(mag)}, 0);
      wait_secs(nsec);
      for (int k = 1; k < nsec; k++) begin
         int a = sec_t[k] - sec_t[k-1];
         int e = exp_len(k, mag, fast);
         n_run++;
         if (a != e) begin
            n_fail++;
            $display("FAIL %s second %0d: actual %0d expected %0d", req, k, a, e);
         end
      end
   endtask

   task automatic t_minute;
      do_reset({1'b1, 5'd1}, 0);
      wait_secs(20);
      for (int k = 0; k < 20; k++)
         check("R10 minute strobe", sec_m[k], (k % SPM == SPM - 1));
   endtask

   task automatic t_midcycle;
      do_reset({1'b0, 5'd0}, 0);
      wait_secs(10);
      cal_word = {1'b1, 5'd4};
      wait_secs(41);
      for (int k = 11; k < 41; k++) begin
         int e = (k >= 32 && k % SPM == 0) ? FAST : NOM;
         check("R7 mid-cycle change", sec_t[k] - sec_t[k-1], e);
      end
   endtask

   task automatic t_tap;
      do_reset({1'b1, 5'd31}, 0);
      wait_secs(10);
      check("R8 tap period under trim", tap_bad, 0);
      if (tap_bad != 0) $display("FAIL R8 last bad interval actual %0d expected 2", tap_bad_v);
      check("R8 tap active", (tap_n > 100), 1);
   endtask

   task automatic t_carry;
      do_reset({1'b1, 5'd0}, 0);
      wait_secs(6);
      check("R9 carry spacing", car_bad, 0);
      if (car_bad != 0) $display("FAIL R9 last bad interval actual %0d expected 16", car_bad_v);
      check("R9 carry count", (car_n >= 6 * SC), 1);
   endtask

   task automatic t_tick;
      int s0;
      logic tp;
      do_reset({1'b0, 5'd0}, 1);
      wait_secs(4);
      for (int k = 1; k < 4; k++)
         check("R11 half-rate second", sec_t[k] - sec_t[k-1], 2 * NOM);
      tick_mode = 2;
      repeat (2) @(negedge clk);
      s0 = n_sec; tp = tap_512;
      repeat (300) @(negedge clk);
      check("R11 frozen seconds", n_sec - s0, 0);
      check("R11 frozen tap", tap_512, tp);
   endtask

   initial begin
      fork
         begin
            t_reset;
            t_lengths("R2 mag0 fast", 0, 1'b1, 12);
            t_lengths("R2 mag0 slow", 0, 1'b0, 12);
            t_lengths("R3 R5 R6 fast mag1", 1, 1'b1, 40);
            t_lengths("R4 R5 R6 slow mag2", 2, 1'b0, 40);
            t_lengths("R6 fast mag31 all minutes", 31, 1'b1, 36);
            t_lengths("R6 slow mag3", 3, 1'b0, 36);
            t_minute;
            t_midcycle;
            t_tap;
            t_carry;
            t_tick;
         end
         begin
            repeat (100000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule